// File: doc/BRIEF.md
# Completion Status Queue for a Four-Channel Storage Host

This block gathers completion records from up to four command-packet engines into one shared queue that host software drains through a simple register read port. When a channel's packet finishes, it raises a push request carrying a 6-bit host status code and an 8-bit device status byte. The queue tags each accepted record with the number of the channel that sent it.

Software pulls each record as two 32-bit words. The first word, at offset 0x0, carries the device status byte. The second word, at offset 0x4, carries the channel number, the host status code, a valid flag and an empty flag. Reading the second word removes the record, so a driver loops until it sees the empty flag. Host status 0 means a packet finished cleanly and 3 means the device reported an error. The queue passes every code through unchanged and leaves its meaning to software.

A one-bit interrupt enable at offset 0x8 gates a level interrupt. The interrupt is high while records are waiting.

Top module: `cstat_fifo`

## Requirements
- R1: A push is accepted in a cycle where `push_ack[i]` is high. The stored record holds channel number i, that channel's `push_hstat` slice and that channel's `push_dstat` slice.
- R2: When several channels request at once, only the lowest-numbered requesting channel is acknowledged in that cycle. The other channels keep requesting and are served in later cycles in ascending channel order.
- R3: The queue holds 8 records and returns them in acceptance order. While it holds 8 records, no `push_ack` is given and no record is lost. A stalled request is accepted once a pop frees a slot.
- R4: A read of offset 0x0 returns the head record's device status in bits 23:16, with all other bits zero. It returns all zeros when the queue is empty. It never removes a record.
- R5: A read of offset 0x4 on a non-empty queue returns bit 31 = 0, bit 30 = 1, the channel number in bits 9:8 and the host status in bits 5:0, with all other bits zero. The read removes that record.
- R6: A read of offset 0x4 on an empty queue returns 0x8000_0000 (empty=1, valid=0) and changes nothing.
- R7: Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read.
- R8: A write to offset 0x8 loads the interrupt enable from bit 0. `irq` is high exactly when the enable is set and the queue is non-empty.
- R9: After reset the queue is empty, the interrupt enable is clear and `irq` is low.
- R10: All 64 host status codes and any device status byte pass through the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | NCH | Per-channel completion push request, held until acknowledged |
| push_hstat | input | NCH*6 | Per-channel host status code, channel i at bits 6i+5:6i |
| push_dstat | input | NCH*8 | Per-channel device status byte, channel i at bits 8i+7:8i |
| push_ack | output | NCH | Per-channel acceptance strobe |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register byte offset for reads |
| rd_data | output | 32 | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register byte offset for writes |
| wr_data | input | 32 | Register write data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest condition to reach is a push that arrives while the queue is full and stays stalled across cycles, then resolves in the same stretch where pops are freeing slots. A priority conflict may be pending at the same time. To get there, the stimulus fills the queue with eight single-channel pushes and holds a ninth request for several cycles, checking that it is refused. It then pops one record and resumes the request.

The stimulus also sweeps every non-empty combination of simultaneous channel requests, so ascending service order is seen under each overlap. It pushes all 64 host status codes through the queue in batches of eight and drains each batch.

// File: rtl/cstat_pkg.sv
package cstat_pkg;
  localparam int HS_W = 6;
  localparam int DS_W = 8;
  localparam int CH_W = 2;
  localparam int REC_W = CH_W + HS_W + DS_W;

  localparam logic [3:0] OFS_LO   = 4'h0;
  localparam logic [3:0] OFS_HI   = 4'h4;
  localparam logic [3:0] OFS_CTRL = 4'h8;

  typedef struct packed {
    logic [CH_W-1:0] chan;
    logic [HS_W-1:0] hstat;
    logic [DS_W-1:0] dstat;
  } rec_t;
endpackage

// File: rtl/cstat_rst_sync.sv
module cstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cstat_arb.sv
module cstat_arb #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic           allow,
  output logic [NCH-1:0] gnt
);
  logic [NCH:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_pri
    assign gnt[i]    = req[i] & ~seen[i] & allow;
    assign seen[i+1] = seen[i] | req[i];
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r3_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |-> (gnt == '0));

  for (genvar i = 1; i < NCH; i++) begin : g_chk
    a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      gnt[i] |-> (req[i-1:0] == '0));
  end

  a_r2_some_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (allow && (req != '0)) |-> (gnt != '0));
endmodule

// File: rtl/cstat_store.sv
module cstat_store
  import cstat_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  rec_t push_rec,
  input  logic pop,
  output rec_t head,
  output logic empty,
  output logic full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rec_t mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    if (pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_rec;
  end

  assign head  = mem[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/cstat_regs.sv
module cstat_regs
  import cstat_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  rec_t              head,
  input  logic              empty,
  output logic              pop,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_HI);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic        ien_q, ien_d;
  logic [31:0] rdat_q, rdat_d;
  logic [31:0] lo_word, hi_word;

  always_comb begin
    lo_word = '0;
    hi_word = '0;
    if (empty) begin
      hi_word[31] = 1'b1;
    end else begin
      lo_word[23:16] = head.dstat;
      hi_word[30]    = 1'b1;
      hi_word[9:8]   = head.chan;
      hi_word[5:0]   = head.hstat;
    end
  end

  always_comb begin
    ien_d  = ien_q;
    rdat_d = rdat_q;
    if (wr_en && (wr_addr == A_CTRL)) ien_d = wr_data[0];
    if (rd_en) begin
      case (rd_addr)
        A_LO:    rdat_d = lo_word;
        A_HI:    rdat_d = hi_word;
        A_CTRL:  rdat_d = {31'b0, ien_q};
        default: rdat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ien_q  <= ien_d;
      rdat_q <= rdat_d;
    end
  end

  assign pop     = rd_en && (rd_addr == A_HI) && !empty;
  assign rd_data = rdat_q;
  assign irq     = ien_q & ~empty;

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  a_r6_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == A_HI) && empty) |=> (rd_data == 32'h8000_0000));

  a_r8_irq_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_CTRL) && !wr_data[0]) |=> !irq);

  a_r8_irq_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !empty);
endmodule

// File: rtl/cstat_fifo.sv
module cstat_fifo
  import cstat_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       push_req,
  input  logic [NCH*HS_W-1:0]  push_hstat,
  input  logic [NCH*DS_W-1:0]  push_dstat,
  output logic [NCH-1:0]       push_ack,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [31:0]          rd_data,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [31:0]          wr_data,
  output logic                 irq
);
  logic rst_s_n;
  logic full, empty, pop, push;
  rec_t head, sel_rec;

  cstat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  cstat_arb #(.NCH(NCH)) u_arb (
    .clk   (clk),
    .rst_n (rst_s_n),
    .req   (push_req),
    .allow (!full),
    .gnt   (push_ack)
  );

  always_comb begin
    sel_rec = '0;
    for (int i = 0; i < NCH; i++) begin
      if (push_ack[i]) begin
        sel_rec.chan  = CH_W'(i);
        sel_rec.hstat = push_hstat[i*HS_W +: HS_W];
        sel_rec.dstat = push_dstat[i*DS_W +: DS_W];
      end
    end
  end

  assign push = |push_ack;

  cstat_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .push     (push),
    .push_rec (sel_rec),
    .pop      (pop),
    .head     (head),
    .empty    (empty),
    .full     (full)
  );

  cstat_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .head    (head),
    .empty   (empty),
    .pop     (pop),
    .rd_data (rd_data),
    .irq     (irq)
  );

  a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    (push_ack & ~push_req) == '0);

  a_r9_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_s_n) |-> !irq);
endmodule

// File: tb/cstat_fifo_bench.sv
module cstat_fifo_bench;
  localparam int NCH = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] push_req;
  logic [NCH*6-1:0] push_hstat;
  logic [NCH*8-1:0] push_dstat;
  logic [NCH-1:0] push_ack;
  logic rd_en;
  logic [3:0] rd_addr;
  logic [31:0] rd_data;
  logic wr_en;
  logic [3:0] wr_addr;
  logic [31:0] wr_data;
  logic irq;

  logic [5:0] b_hs [NCH];
  logic [7:0] b_ds [NCH];
  logic [15:0] mq [$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      push_hstat[i*6 +: 6] = b_hs[i];
      push_dstat[i*8 +: 8] = b_ds[i];
    end
  end

  cstat_fifo u_cstat_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_hstat(push_hstat),
    .push_dstat(push_dstat), .push_ack(push_ack), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_push(input logic [3:0] mask, input int maxc, output logic [3:0] left);
    logic [3:0] pend, ex;
    int cyc;
    pend = mask; cyc = 0;
    while (pend != 0 && cyc < maxc) begin
      @(negedge clk); push_req = pend;
      #1;
      ex = (mq.size() >= DEPTH) ? 4'b0 : (pend & (~pend + 4'd1));
      chk((ex == 0) ? "R3 stall when full" : "R2 lowest channel first", {28'b0, push_ack}, {28'b0, ex});
      for (int i = 0; i < NCH; i++)
        if (push_ack[i]) mq.push_back({i[1:0], b_hs[i], b_ds[i]});
      pend = pend & ~push_ack;
      @(posedge clk); cyc++;
    end
    @(negedge clk); push_req = '0;
    left = pend;
  endtask

  task automatic pop_one();
    logic [31:0] d;
    logic [15:0] r;
    if (mq.size() == 0) begin
      do_read(4'h0, d); chk("R4 empty low word", d, 32'h0);
      do_read(4'h4, d); chk("R6 empty high word", d, 32'h8000_0000);
    end else begin
      r = mq[0];
      do_read(4'h0, d); chk("R4 low word", d, {8'h0, r[7:0], 16'h0});
      do_read(4'h4, d); chk("R5 R10 high word", d, {2'b01, 20'b0, r[15:14], 2'b00, r[13:8]});
      void'(mq.pop_front());
    end
  endtask

  task automatic drain();
    while (mq.size() > 0) pop_one();
    pop_one();
  endtask

  initial begin
    logic [31:0] d;
    logic [3:0] left;
    rst_n = 1'b0; push_req = '0; rd_en = 0; rd_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    for (int i = 0; i < NCH; i++) begin b_hs[i] = '0; b_ds[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 irq low after reset", {31'b0, irq}, 32'h0);
    do_read(4'h8, d); chk("R9 enable clear after reset", d, 32'h0);
    do_read(4'h4, d); chk("R9 R6 empty after reset", d, 32'h8000_0000);
    do_read(4'h0, d); chk("R4 empty low", d, 32'h0);
    do_read(4'h4, d); chk("R6 empty read changes nothing", d, 32'h8000_0000);

    // R8 interrupt
    do_write(4'h8, 32'h1);
    chk("R8 no irq while empty", {31'b0, irq}, 32'h0);
    b_hs[2] = 6'd0; b_ds[2] = 8'h50;
    run_push(4'b0100, 4, left);
    chk("R1 single push accepted", {28'b0, left}, 32'h0);
    chk("R8 irq with entry", {31'b0, irq}, 32'h1);
    do_write(4'h8, 32'h0);
    chk("R8 irq off when disabled", {31'b0, irq}, 32'h0);
    do_write(4'h8, 32'h1);
    chk("R8 irq back on", {31'b0, irq}, 32'h1);

    // R4 low word never pops; R7 read data holds
    do_read(4'h0, d); chk("R4 low word", d, 32'h0050_0000);
    repeat (3) @(negedge clk);
    chk("R7 read data holds", rd_data, 32'h0050_0000);
    do_read(4'h0, d); chk("R4 low word again, no pop", d, 32'h0050_0000);
    drain();
    chk("R8 irq low after drain", {31'b0, irq}, 32'h0);

    // R2 every overlap of simultaneous requests
    for (int m = 1; m < 16; m++) begin
      for (int i = 0; i < NCH; i++) begin
        b_hs[i] = 6'((m * 5 + i * 11) & 63);
        b_ds[i] = 8'((m * 29 + i * 71) & 255);
      end
      run_push(m[3:0], 8, left);
      chk("R2 all requests served", {28'b0, left}, 32'h0);
      drain();
    end

    // R3 full queue stalls and nothing is lost
    for (int k = 0; k < DEPTH; k++) begin
      b_hs[1] = 6'(k + 3); b_ds[1] = 8'(k * 17 + 1);
      run_push(4'b0010, 4, left);
    end
    b_hs[3] = 6'd63; b_ds[3] = 8'hEE;
    run_push(4'b1000, 3, left);
    chk("R3 ninth push stalled", {28'b0, left}, 32'h0000_0008);
    pop_one();
    run_push(4'b1000, 3, left);
    chk("R3 stalled push accepted after pop", {28'b0, left}, 32'h0);
    drain();

    // R10 sweep of all host status codes
    for (int b = 0; b < 8; b++) begin
      for (int k = 0; k < 8; k++) begin
        int c;
        int code;
        code = b * 8 + k;
        c = code % NCH;
        b_hs[c] = 6'(code);
        b_ds[c] = 8'((code * 37 + 11) & 255);
        run_push(4'(1 << c), 4, left);
      end
      drain();
    end

    chk("R8 irq low at end", {31'b0, irq}, 32'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule